// File: doc/BRIEF.md
# Accumulator Transfer Limiter

This block holds one wide accumulator and handles every 16-bit transfer into or out of it. The accumulator is split into a guard field at the top (4 bits by default), an upper word and a lower word, 36 bits in all. A register-move datapath names a part on each transfer: either the whole accumulator or one of its three parts. A write to the whole accumulator places the 16-bit value in the upper word, copies its sign bit into the guard field and clears the lower word. A write to a single part changes only that part.

A read of the whole accumulator returns the upper word, unless the guard field together with the top bit of the upper word shows that the value no longer fits in 16 bits. In that case the block returns the largest positive or negative 16-bit constant, picked by the accumulator's sign, and sets a sticky limit flag. Block floating-point code can then run a whole loop and test the flag once. Reads of a single part never limit and never touch the flag. The flag stays set until the clear input is pulsed.

Top module: `acc_xfer_unit`

## Requirements
- R1: After reset the accumulator is all zeros and the limit flag is low.
- R2: A write with part code 00 (whole) loads the upper word with the data, fills the guard field with copies of data bit 15, and sets the lower word to zero. The new value is visible on acc_out one cycle later.
- R3: A write with part code 01 (upper word) replaces bits 31:16 only. The guard field and the lower word keep their values.
- R4: A write with part code 10 (lower word) replaces bits 15:0 only.
- R5: A write with part code 11 (guard) loads the guard field from the low 4 data bits. The other 32 bits keep their values.
- R6: A read with part code 00 returns bits 31:16 when bits 35 to 31 are all equal.
- R7: A read with part code 00 returns 16'h7FFF when bits 35 to 31 are not all equal and bit 35 is 0. It returns 16'h8000 in the same case when bit 35 is 1.
- R8: Reads with part codes 01 and 10 return bits 31:16 and 15:0 unchanged, even when the guard is in use, and they never set the limit flag.
- R9: The limit flag goes high on the clock edge that ends a limited whole read with rd_en high. It stays high through later unlimited reads and writes.
- R10: A lim_clr pulse clears the flag on the next edge. When a limited whole read happens in the same cycle as a clear, the flag is set.
- R11: A read with part code 11 returns the guard field sign-extended to 16 bits.
- R12: With rd_en low, rd_data still shows the selected value, but the limit flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Part code for the write: 00 whole, 01 upper, 10 lower, 11 guard |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; only a strobed read can set the flag |
| rd_sel | input | 2 | Part code for the read, same encoding as wr_sel |
| rd_data | output | 16 | Read result, combinational from the stored accumulator |
| lim_clr | input | 1 | Clear pulse for the limit flag |
| lim_flag | output | 1 | Sticky limit flag |
| acc_out | output | 36 | Stored accumulator contents |

## Verification
The hardest case to create from the ports is an overflow carried only by bit 31, where the guard field still agrees with the accumulator's sign. A whole write can never produce this state, because it always makes the guard match bit 15 of the data. The bench first writes the whole accumulator and then overwrites only the upper word, with 16'h8000 under a zero guard and with 16'h0000 under an all-ones guard. This checks that the one-bit disagreement saturates in both directions. A second hard case is a clear that lands in the same cycle as a limited read. The bench drives both strobes in the same cycle to check that the set wins.

// File: rtl/acc_xfer_pkg.sv
// Package: shared part-select encoding for the accumulator transfer unit.
// Assumes every part select in the unit is exactly two bits wide.
package acc_xfer_pkg;
    typedef enum logic [1:0] {
        PART_WHOLE = 2'b00,
        PART_HIGH  = 2'b01,
        PART_LOW   = 2'b10,
        PART_GUARD = 2'b11
    } part_sel_e;
endpackage

// File: rtl/acc_store.sv
// Module: acc_store
// Holds the accumulator as three fields and applies one write per cycle.
// A whole write sign-extends the data into the guard and zeroes the low word.
// Part writes touch only their own field.
// Assumes a synchronous active-low reset and WORD_W > GUARD_W.
module acc_store
    import acc_xfer_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int GUARD_W = 4,
    localparam int ACC_W  = GUARD_W + 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  part_sel_e         wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [ACC_W-1:0]  acc_q
);
    logic [GUARD_W-1:0] guard_q;
    logic [WORD_W-1:0]  high_q;
    logic [WORD_W-1:0]  low_q;

    // Guard field: sign copy on a whole write, direct load on a guard write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= '0;
        end else if (wr_en && wr_sel == PART_WHOLE) begin
            guard_q <= {GUARD_W{wr_data[WORD_W-1]}};
        end else if (wr_en && wr_sel == PART_GUARD) begin
            guard_q <= wr_data[GUARD_W-1:0];
        end
    end

    // Upper word: loaded by both whole and upper-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_q <= '0;
        end else if (wr_en && (wr_sel == PART_WHOLE || wr_sel == PART_HIGH)) begin
            high_q <= wr_data;
        end
    end

    // Lower word: zeroed by a whole write, loaded by a lower-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (wr_en && wr_sel == PART_WHOLE) begin
            low_q <= '0;
        end else if (wr_en && wr_sel == PART_LOW) begin
            low_q <= wr_data;
        end
    end

    // Concatenate the fields into the accumulator view.
    always_comb acc_q = {guard_q, high_q, low_q};

    p_whole_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == PART_WHOLE) |=>
            (acc_q == {{GUARD_W{$past(wr_data[WORD_W-1])}}, $past(wr_data), {WORD_W{1'b0}}}));

    p_high_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == PART_HIGH) |=>
            (acc_q[WORD_W-1:0] == $past(acc_q[WORD_W-1:0]) &&
             acc_q[ACC_W-1:2*WORD_W] == $past(acc_q[ACC_W-1:2*WORD_W])));

    p_low_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == PART_LOW) |=>
            (acc_q[ACC_W-1:WORD_W] == $past(acc_q[ACC_W-1:WORD_W])));
endmodule

// File: rtl/acc_limiter.sv
// Module: acc_limiter
// Combinational read path: selects the requested part and, for a whole read,
// clamps to the signed 16-bit limits when the guard bits plus the upper
// word's MSB disagree. Flags sat_hit whenever the clamp is applied.
// Assumes WORD_W > GUARD_W.
module acc_limiter
    import acc_xfer_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int GUARD_W = 4,
    localparam int ACC_W  = GUARD_W + 2 * WORD_W,
    localparam int CHK_W  = GUARD_W + 1
) (
    input  logic [ACC_W-1:0]  acc,
    input  part_sel_e         rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              sat_hit
);
    localparam logic [WORD_W-1:0] POS_LIM = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_LIM = {1'b1, {(WORD_W-1){1'b0}}};

    logic [CHK_W-1:0]   chk_bits;
    logic               guard_used;
    logic [WORD_W-1:0]  whole_val;

    // Overflow check: the guard and bit 2W-1 must all agree.
    always_comb begin
        chk_bits   = acc[ACC_W-1:2*WORD_W-1];
        guard_used = !((&chk_bits) || !(|chk_bits));
    end

    // Whole-read value: clamped constant or the plain upper word.
    always_comb begin
        if (guard_used) begin
            whole_val = acc[ACC_W-1] ? NEG_LIM : POS_LIM;
        end else begin
            whole_val = acc[2*WORD_W-1:WORD_W];
        end
    end

    // Part mux, with the guard read sign-extended to a full word.
    always_comb begin
        sat_hit = 1'b0;
        unique case (rd_sel)
            PART_WHOLE: begin
                rd_data = whole_val;
                sat_hit = guard_used;
            end
            PART_HIGH:  rd_data = acc[2*WORD_W-1:WORD_W];
            PART_LOW:   rd_data = acc[WORD_W-1:0];
            PART_GUARD: rd_data = {{(WORD_W-GUARD_W){acc[ACC_W-1]}}, acc[ACC_W-1:2*WORD_W]};
            default:    rd_data = '0;
        endcase
    end

    // R7: a clamped result is always one of the two limit constants.
    always_comb begin
        if (sat_hit) begin
            p_sat_const_r7: assert (rd_data == POS_LIM || rd_data == NEG_LIM);
        end
    end
endmodule

// File: rtl/lim_sticky.sv
// Module: lim_sticky
// Sticky limit flag: a set wins over a clear in the same cycle.
// Assumes a synchronous active-low reset.
module lim_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    // Flag update: set has priority, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
endmodule

// File: rtl/acc_xfer_unit.sv
// Module: acc_xfer_unit (top)
// Connects the accumulator store, the limiting read path and the sticky flag.
// Only a strobed whole read can set the flag.
// Assumes the part encodings from acc_xfer_pkg on wr_sel and rd_sel.
module acc_xfer_unit
    import acc_xfer_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int GUARD_W = 4,
    localparam int ACC_W  = GUARD_W + 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              lim_clr,
    output logic              lim_flag,
    output logic [ACC_W-1:0]  acc_out
);
    part_sel_e         wr_part;
    part_sel_e         rd_part;
    logic [ACC_W-1:0]  acc_q;
    logic              sat_hit;
    logic              lim_set;

    // Decode the raw select pins into the shared part type.
    always_comb begin
        wr_part = part_sel_e'(wr_sel);
        rd_part = part_sel_e'(rd_sel);
    end

    acc_store #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_part),
        .wr_data (wr_data),
        .acc_q   (acc_q)
    );

    acc_limiter #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_limiter (
        .acc     (acc_q),
        .rd_sel  (rd_part),
        .rd_data (rd_data),
        .sat_hit (sat_hit)
    );

    // Only a strobed read that actually clamped may set the flag.
    always_comb lim_set = rd_en && sat_hit;

    lim_sticky u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (lim_set),
        .clr_i  (lim_clr),
        .flag_q (lim_flag)
    );

    // Expose the stored accumulator.
    always_comb acc_out = acc_q;

    p_part_read_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel != 2'b00 && !lim_flag) |=> !lim_flag);

    p_idle_read_no_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !lim_flag) |=> !lim_flag);
endmodule

// File: tb/acc_xfer_unit_tb.sv
`timescale 1ns/1ps
module acc_xfer_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'b00;
    logic [15:0] rd_data;
    logic        lim_clr = 1'b0;
    logic        lim_flag;
    logic [35:0] acc_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_xfer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .lim_clr(lim_clr), .lim_flag(lim_flag), .acc_out(acc_out)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Strobed read: samples rd_data mid-cycle; the flag is visible at the next negedge.
    task automatic do_read(input logic [1:0] sel, input logic strobe, output logic [15:0] v);
        @(negedge clk);
        rd_en = strobe; rd_sel = sel;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        lim_clr = 1'b1;
        @(negedge clk);
        lim_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 acc", acc_out, 36'h0);
        chk("R1 flag", {35'h0, lim_flag}, 36'h0);
    endtask

    task automatic t_whole_write();
        logic [15:0] v;
        do_write(2'b00, 16'h1234);
        chk("R2 positive", acc_out, 36'h0_1234_0000);
        do_write(2'b10, 16'hBEEF);
        do_write(2'b00, 16'h9ABC);
        chk("R2 negative, low zeroed", acc_out, 36'hF_9ABC_0000);
        do_read(2'b00, 1'b1, v);
        chk("R6 unlimited read", {20'h0, v}, {20'h0, 16'h9ABC});
        chk("R6 no flag", {35'h0, lim_flag}, 36'h0);
    endtask

    task automatic t_part_writes();
        do_write(2'b10, 16'h5555);
        chk("R4 low only", acc_out, 36'hF_9ABC_5555);
        do_write(2'b01, 16'h0123);
        chk("R3 high only", acc_out, 36'hF_0123_5555);
        do_write(2'b11, 16'hFFF5);
        chk("R5 guard only", acc_out, 36'h5_0123_5555);
    endtask

    task automatic t_part_reads();
        logic [15:0] v;
        do_read(2'b01, 1'b1, v);
        chk("R8 high read", {20'h0, v}, {20'h0, 16'h0123});
        do_read(2'b10, 1'b1, v);
        chk("R8 low read", {20'h0, v}, {20'h0, 16'h5555});
        do_read(2'b11, 1'b1, v);
        chk("R11 guard read positive", {20'h0, v}, {20'h0, 16'h0005});
        chk("R8 no flag from part reads", {35'h0, lim_flag}, 36'h0);
    endtask

    task automatic t_sat_positive();
        logic [15:0] v;
        do_read(2'b00, 1'b0, v);
        chk("R12 unstrobed value", {20'h0, v}, {20'h0, 16'h7FFF});
        chk("R12 unstrobed no flag", {35'h0, lim_flag}, 36'h0);
        do_read(2'b00, 1'b1, v);
        chk("R7 clamp positive", {20'h0, v}, {20'h0, 16'h7FFF});
        chk("R9 flag set", {35'h0, lim_flag}, 36'h1);
        do_write(2'b00, 16'h0001);
        do_read(2'b00, 1'b1, v);
        chk("R6 small value", {20'h0, v}, {20'h0, 16'h0001});
        chk("R9 flag sticky", {35'h0, lim_flag}, 36'h1);
        pulse_clear();
        chk("R10 cleared", {35'h0, lim_flag}, 36'h0);
    endtask

    task automatic t_bit31_edges();
        logic [15:0] v;
        do_write(2'b00, 16'h0000);
        do_write(2'b01, 16'h8000);
        do_read(2'b00, 1'b1, v);
        chk("R7 bit31 only, positive", {20'h0, v}, {20'h0, 16'h7FFF});
        pulse_clear();
        do_write(2'b11, 16'h000F);
        do_write(2'b01, 16'h0000);
        chk("R3 setup", acc_out, 36'hF_0000_0000);
        do_read(2'b00, 1'b1, v);
        chk("R7 bit31 only, negative", {20'h0, v}, {20'h0, 16'h8000});
        do_read(2'b11, 1'b1, v);
        chk("R11 guard read negative", {20'h0, v}, {20'h0, 16'hFFFF});
    endtask

    task automatic t_set_vs_clear();
        logic [15:0] v;
        pulse_clear();
        chk("R10 clear before race", {35'h0, lim_flag}, 36'h0);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = 2'b00; lim_clr = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; lim_clr = 1'b0;
        chk("R7 race value", {20'h0, v}, {20'h0, 16'h8000});
        chk("R10 set wins over clear", {35'h0, lim_flag}, 36'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 t_reset();
        t_whole_write();
        t_part_writes();
        t_part_reads();
        t_sat_positive();
        t_bit31_edges();
        t_set_vs_clear();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule